// File: doc/BRIEF.md
# Power-Good Reset Generator

This block decides whether a monitored supply rail is good. It reads two comparator flags. The first says the rail is above an upper threshold near 94 % of nominal. The second says the rail is below a lower threshold near 90 % of nominal. From these it drives an active-low reset line that stands for an open-drain pin: the line is pulled low while the rail is not good and released while it is.

The gap between the two thresholds gives hysteresis. Two persistence timers add a qualification window on each side. The rail must stay above the upper threshold for a long entry window before it is declared good. It must stay below the lower threshold for a short exit window before it is declared bad. Both windows are cycle counts supplied on input ports, so the integrating logic can scale them together, as a timing capacitor would. The exit window has a parameterised floor, so a glitch shorter than the floor can never drop the reset line. A disable of the monitored channel forces the bad state at once.

Top module: `pgood_reset_gen`

## Requirements
- R1: While `rst` is high, and after the first clock edge that samples it high, `pwr_good` is 0 and `rst_drive_low` is 1.
- R2: In the not-good state, `pwr_good` becomes 1 on the clock edge that samples `rail_above_hi` high for the Nth consecutive edge, where N is `entry_cnt`.
- R3: In the good state, `pwr_good` becomes 0 on the clock edge that samples `rail_below_lo` high for the Mth consecutive edge, where M is the larger of `exit_cnt` and the parameter `EXIT_MIN`.
- R4: An edge on which the qualifying flag is low restarts the running window from zero. That flag is `rail_above_hi` in the not-good state and `rail_below_lo` in the good state.
- R5: When neither flag is high (the rail sits between the thresholds), the state does not change, however long that lasts.
- R6: `rst_drive_low` is always the inverse of `pwr_good`: 1 means pull low and 0 means released.
- R7: An edge that samples `chan_en` low forces `pwr_good` to 0 after that edge and clears any running window. After `chan_en` returns high, a full entry window is needed.
- R8: An `exit_cnt` below `EXIT_MIN`, including 0, is treated as `EXIT_MIN`.
- R9: An `entry_cnt` of 0 is treated as 1, so a single qualifying edge declares the rail good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_above_hi | input | 1 | Comparator flag: rail above upper threshold |
| rail_below_lo | input | 1 | Comparator flag: rail below lower threshold |
| chan_en | input | 1 | Monitored channel is enabled |
| entry_cnt | input | CNT_W | Entry persistence window in cycles |
| exit_cnt | input | CNT_W | Exit persistence window in cycles (floored at EXIT_MIN) |
| rst_drive_low | output | 1 | 1 = pull reset line low, 0 = release |
| pwr_good | output | 1 | Power-good status |

## Verification
The assertions check on every cycle that the reset drive is the inverse of the status, that a channel disable forces the bad state, and that a rise in status is preceded by a high upper flag. They also check that the state holds while the rail sits between the thresholds, and that no exit happens before the lower flag has been high for at least the floor. The exact length of each window cannot be seen by a property, because the windows depend on the programmed counts. Neither can the restart after an interruption, or the treatment of zero counts. Those are shown by the bench's directed sequences and by its cycle-by-cycle reference model under random flag activity.

// File: rtl/pgood_pkg.sv
package pgood_pkg;

  typedef enum logic {
    PG_BAD  = 1'b0,
    PG_GOOD = 1'b1
  } pg_state_e;

  // Raise a programmed count to a floor value.
  function automatic logic [31:0] floor_to(input logic [31:0] val, input logic [31:0] floor_v);
    return (val < floor_v) ? floor_v : val;
  endfunction

endpackage

// File: rtl/pgood_limits.sv
module pgood_limits #(
  parameter int CNT_W    = 24,
  parameter int EXIT_MIN = 500
) (
  input  logic [CNT_W-1:0] entry_cnt,
  input  logic [CNT_W-1:0] exit_cnt,
  output logic [CNT_W-1:0] entry_lim,
  output logic [CNT_W-1:0] exit_lim
);
  import pgood_pkg::*;

  localparam logic [31:0] ENTRY_FLOOR = 32'd1;
  localparam logic [31:0] EXIT_FLOOR  = 32'(EXIT_MIN);

  logic [31:0] entry_w;
  logic [31:0] exit_w;
  logic [31:0] entry_f;
  logic [31:0] exit_f;

  always_comb begin
    entry_w   = 32'(entry_cnt);
    exit_w    = 32'(exit_cnt);
    entry_f   = floor_to(entry_w, ENTRY_FLOOR);
    exit_f    = floor_to(exit_w, EXIT_FLOOR);
    entry_lim = entry_f[CNT_W-1:0];
    exit_lim  = exit_f[CNT_W-1:0];
  end

endmodule

// File: rtl/pgood_persist_timer.sv
module pgood_persist_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             qualify,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   run_inc;

  always_comb begin
    run_inc = {1'b0, run_q} + {{CNT_W{1'b0}}, 1'b1};
    expire  = qualify && !clr && (run_inc >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !qualify || expire) begin
      run_q <= '0;
    end else begin
      run_q <= run_inc[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/pgood_state_reg.sv
module pgood_state_reg (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic flip,
  output logic good,
  output logic drive_low
);
  import pgood_pkg::*;

  pg_state_e state_q;
  pg_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = PG_BAD;
    end else if (flip) begin
      state_d = (state_q == PG_GOOD) ? PG_BAD : PG_GOOD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PG_BAD;
      drive_low <= 1'b1;
    end else begin
      state_q   <= state_d;
      drive_low <= (state_d == PG_BAD);
    end
  end

  assign good = (state_q == PG_GOOD);

endmodule

// File: rtl/pgood_reset_gen.sv
module pgood_reset_gen #(
  parameter int CNT_W    = 24,
  parameter int EXIT_MIN = 500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rail_above_hi,
  input  logic             rail_below_lo,
  input  logic             chan_en,
  input  logic [CNT_W-1:0] entry_cnt,
  input  logic [CNT_W-1:0] exit_cnt,
  output logic             rst_drive_low,
  output logic             pwr_good
);

  logic [CNT_W-1:0] entry_lim;
  logic [CNT_W-1:0] exit_lim;
  logic [CNT_W-1:0] active_lim;
  logic             qualify;
  logic             expire;
  logic             good_q;
  logic             drive_q;

  pgood_limits #(
    .CNT_W    (CNT_W),
    .EXIT_MIN (EXIT_MIN)
  ) u_limits (
    .entry_cnt (entry_cnt),
    .exit_cnt  (exit_cnt),
    .entry_lim (entry_lim),
    .exit_lim  (exit_lim)
  );

  // One window counter serves both directions: the state picks the flag and limit.
  always_comb begin
    qualify    = good_q ? rail_below_lo : rail_above_hi;
    active_lim = good_q ? exit_lim : entry_lim;
  end

  pgood_persist_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (!chan_en),
    .qualify (qualify),
    .limit   (active_lim),
    .expire  (expire)
  );

  pgood_state_reg u_state (
    .clk       (clk),
    .rst       (rst),
    .en        (chan_en),
    .flip      (expire),
    .good      (good_q),
    .drive_low (drive_q)
  );

  assign pwr_good      = good_q;
  assign rst_drive_low = drive_q;

endmodule

// File: rtl/pgood_checker.sv
module pgood_checker #(
  parameter int CNT_W    = 24,
  parameter int EXIT_MIN = 500
) (
  input logic clk,
  input logic rst,
  input logic rail_above_hi,
  input logic rail_below_lo,
  input logic chan_en,
  input logic rst_drive_low,
  input logic pwr_good
);

  logic [CNT_W:0] below_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      below_run <= '0;
    end else if (pwr_good && rail_below_lo && chan_en) begin
      below_run <= (&below_run) ? below_run : below_run + 1'b1;
    end else begin
      below_run <= '0;
    end
  end

  p_out_inverse_r6: assert property (@(posedge clk) disable iff (rst)
    rst_drive_low == !pwr_good)
    else $error("R6: drive and status disagree");

  p_disable_forces_bad_r7: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (!pwr_good && rst_drive_low))
    else $error("R7: disable did not force bad state");

  p_rise_needs_above_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwr_good) && !$past(rst)) |-> $past(rail_above_hi))
    else $error("R2: good without upper flag");

  p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
    (chan_en && !rail_above_hi && !rail_below_lo) |=> $stable(pwr_good))
    else $error("R5: state moved between thresholds");

  p_fall_cause_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwr_good) && !$past(rst)) |-> ($past(rail_below_lo) || !$past(chan_en)))
    else $error("R3: fall without lower flag or disable");

  p_exit_floor_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwr_good) && !$past(rst) && $past(chan_en)) |-> (below_run >= (CNT_W+1)'(EXIT_MIN)))
    else $error("R8: exit shorter than floor");

endmodule

bind pgood_reset_gen pgood_checker #(
  .CNT_W    (CNT_W),
  .EXIT_MIN (EXIT_MIN)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rail_above_hi (rail_above_hi),
  .rail_below_lo (rail_below_lo),
  .chan_en       (chan_en),
  .rst_drive_low (rst_drive_low),
  .pwr_good      (pwr_good)
);

// File: tb/pgood_reset_gen_tb.sv
`timescale 1ns/1ps
module pgood_reset_gen_tb;

  localparam int CNT_W    = 12;
  localparam int EXIT_MIN = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             above = 1'b0;
  logic             below = 1'b0;
  logic             en = 1'b0;
  logic [CNT_W-1:0] entry_cnt = '0;
  logic [CNT_W-1:0] exit_cnt = '0;
  logic             drive_low;
  logic             good;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  int  m_good = 0;
  int  m_run  = 0;

  always #10 clk = ~clk;

  pgood_reset_gen #(
    .CNT_W    (CNT_W),
    .EXIT_MIN (EXIT_MIN)
  ) u_dut (
    .clk           (clk),
    .rst           (rst),
    .rail_above_hi (above),
    .rail_below_lo (below),
    .chan_en       (en),
    .entry_cnt     (entry_cnt),
    .exit_cnt      (exit_cnt),
    .rst_drive_low (drive_low),
    .pwr_good      (good)
  );

  function automatic int exp_entry(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_exit(input int v);
    return (v < EXIT_MIN) ? EXIT_MIN : v;
  endfunction

  // Reference model of the requirements, advanced on each clock edge.
  always @(posedge clk) begin
    int lim;
    bit q;
    if (rst || !en) begin
      m_good = 0;
      m_run  = 0;
    end else begin
      q   = (m_good != 0) ? below : above;
      lim = (m_good != 0) ? exp_exit(int'(exit_cnt)) : exp_entry(int'(entry_cnt));
      if (q) begin
        m_run++;
        if (m_run >= lim) begin
          m_good = (m_good != 0) ? 0 : 1;
          m_run  = 0;
        end
      end else begin
        m_run = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic act_good, input logic exp_good);
    n_checks++;
    if (act_good !== exp_good || drive_low !== !exp_good) begin
      n_fail++;
      $display("FAIL %s: good=%b drive_low=%b expected good=%b drive_low=%b",
               tag, act_good, drive_low, exp_good, !exp_good);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    step(3);
    chk("R1 reset", good, 1'b0);
    rst = 1'b0;

    // R2: entry window of 10, R6 output polarity
    en = 1'b1; entry_cnt = 10; exit_cnt = 2; above = 1'b1;
    step(9);  chk("R2 before entry window", good, 1'b0);
    step(1);  chk("R2 entry reached", good, 1'b1);
    chk("R6 released when good", good, 1'b1);

    // R8: exit_cnt 2 floored to 6
    above = 1'b0; below = 1'b1;
    step(5);  chk("R8 floor not yet met", good, 1'b1);
    step(1);  chk("R8 floor met", good, 1'b0);
    chk("R6 pulled low when bad", good, 1'b0);

    // R5 hold in bad state
    below = 1'b0;
    step(20); chk("R5 hold bad", good, 1'b0);

    // R4 entry restart
    above = 1'b1; step(9);
    above = 1'b0; step(1);
    above = 1'b1; step(9);
    chk("R4 entry restarted", good, 1'b0);
    step(1);  chk("R4 entry after restart", good, 1'b1);

    // R5 hold in good state
    above = 1'b0;
    step(20); chk("R5 hold good", good, 1'b1);

    // R3 exit window of 9
    exit_cnt = 9; below = 1'b1;
    step(8);  chk("R3 before exit window", good, 1'b1);
    step(1);  chk("R3 exit reached", good, 1'b0);

    // R4 exit restart
    below = 1'b0; above = 1'b1;
    step(10); chk("R2 re-entry", good, 1'b1);
    above = 1'b0; below = 1'b1; step(8);
    below = 1'b0; step(1);
    below = 1'b1; step(8);
    chk("R4 exit restarted", good, 1'b1);
    step(1);  chk("R4 exit after restart", good, 1'b0);

    // R7 channel disable
    below = 1'b0; above = 1'b1;
    step(10); chk("R7 good before disable", good, 1'b1);
    en = 1'b0; step(1);
    chk("R7 forced bad", good, 1'b0);
    en = 1'b1; step(9);
    chk("R7 window cleared", good, 1'b0);
    step(1);  chk("R7 full entry after enable", good, 1'b1);

    // R9 zero entry count
    above = 1'b0; below = 1'b1;
    step(9);  chk("R9 setup bad", good, 1'b0);
    entry_cnt = 0; below = 1'b0; above = 1'b1;
    step(1);  chk("R9 single-edge entry", good, 1'b1);

    // Random phase against the reference model
    for (int i = 0; i < 5000; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 7)       begin above = 1'b1; below = 1'b0; end
      else if (r < 10) begin above = 1'b0; below = 1'b0; end
      else             begin above = 1'b0; below = 1'b1; end
      en = ($urandom % 64) != 0;
      if ($urandom % 200 == 0) entry_cnt = CNT_W'($urandom % 16);
      if ($urandom % 200 == 0) exit_cnt  = CNT_W'($urandom % 12);
      step(1);
      chk("R2/R3 random vs model", good, (m_good != 0));
    end

    finish_run();
  end

endmodule